// File: doc/BRIEF.md
# I2C Dynamic Command Sequencer

This block sits in front of the bit-level engine of an I2C master. Software frames a whole transfer as a stream of 10-bit entries. The entries go into a 16-deep transmit queue. Each entry holds one byte and two framing flags. Bit 8 asks for a start condition before the byte. Bit 9 asks for a stop condition after the transfer it closes. The sequencer takes entries off the queue one at a time and turns them into single bus commands for the engine: start, repeated start, write byte, read byte (acknowledge or not-acknowledge) and stop. It waits for the engine to report completion of each command before it issues the next.

An entry with the start flag is an address. Its bits 7:1 hold the target and bit 0 gives the direction. After a read address, the sequencer takes the next entry as a byte count and not as data. Received bytes come out on a strobe. If the target does not acknowledge a written byte, the sequencer raises an error pulse and discards the rest of that message. It then releases the bus and continues with the next framed message.

Top module: `i2c_dyn_seq`

## Requirements
- R1: The queue holds DEPTH (16) entries. A push while `full_o` is high is dropped and leaves the contents unchanged. `occupancy_o` shows the entry count minus one, and shows 0 when the queue is empty.
- R2: While `fifo_rst_i` is high, the queue is emptied on the next clock edge. After that, `occupancy_o` is 0 and `tx_empty_o` is 1.
- R3: While `enable_i` is low, no entry is taken from the queue and no new command is issued.
- R4: An entry with bit 8 set produces a start command (cmd 1) when the bus is not owned, or a repeated-start command (cmd 2) when it is owned. A write command (cmd 3) carrying the entry's byte follows.
- R5: A write entry with bit 9 set is followed, after its byte completes with an acknowledge, by a stop command (cmd 5). When the stop completes, `bus_free_o` pulses for one cycle and `bus_owned_o` falls.
- R6: After an address entry whose bit 0 is 1, the next entry's bits 7:0 give a count N. N read commands (cmd 4) follow. `cmd_nack_o` is 0 on all of them except the last, where it is 1. A stop follows only if bit 9 of the count entry is set.
- R7: Each completed read places `rd_data_i` on `rx_data_o` with a one-cycle `rx_valid_o` pulse, in the order received.
- R8: A write that completes with `nack_i` high pulses `tx_err_o`. The sequencer then discards entries until the queue is empty or the head carries bit 8, and then issues a stop.
- R9: `tx_empty_o` is high exactly when the queue holds no entry. `tx_half_o` is high when the queue holds DEPTH/2 entries or fewer.
- R10: While `cmd_valid_o` is high and `done_i` has not arrived, `cmd_o`, `cmd_byte_o` and `cmd_nack_o` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows entries to be consumed |
| fifo_rst_i | input | 1 | Empties the transmit queue |
| push_i | input | 1 | Writes push_data_i into the queue |
| push_data_i | input | 10 | Entry: bit 9 stop, bit 8 start, bits 7:0 byte |
| occupancy_o | output | 4 | Entry count minus one |
| full_o | output | 1 | Queue full |
| tx_empty_o | output | 1 | Queue empty |
| tx_half_o | output | 1 | Queue at or below half |
| cmd_valid_o | output | 1 | A command is pending at the engine |
| cmd_o | output | 3 | 1 start, 2 repeated start, 3 write, 4 read, 5 stop |
| cmd_byte_o | output | 8 | Byte to write (0 otherwise) |
| cmd_nack_o | output | 1 | On a read: answer with not-acknowledge |
| done_i | input | 1 | Engine finished the pending command |
| nack_i | input | 1 | Target did not acknowledge (with done_i) |
| rd_data_i | input | 8 | Received byte (with done_i) |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| tx_err_o | output | 1 | Pulse: written byte not acknowledged |
| bus_free_o | output | 1 | Pulse: stop completed |
| bus_owned_o | output | 1 | Bus held by this master |

## Verification
The assertions assume that the engine raises `done_i` only while `cmd_valid_o` is high, and only for one cycle per command. They also assume that `nack_i` and `rd_data_i` are valid only alongside `done_i`. The bench engine model keeps to this. It waits two cycles with a command pending, pulses `done_i` for a single cycle, and then lowers it before it counts again. It drives not-acknowledge only for one chosen write byte. Every message pushed is well framed, so the sequencer never sees a data entry outside an owned bus.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int ENTRY_W  = 10;
  localparam int START_B  = 8;
  localparam int STOP_B   = 9;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_RESTART = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_READ    = 3'd4,
    CMD_STOP    = 3'd5
  } i2c_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_COND, S_WRITE, S_READ, S_FLUSH, S_STOP
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 10,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: ;
      endcase
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> $stable(count_o));
  assert_no_underflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_clear_empties_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/i2c_seq_level.sv
module i2c_seq_level #(
  parameter int DEPTH = 16,
  localparam int OCC_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [OCC_W-1:0] occupancy_o,
  output logic             half_o
);
  logic [CNT_W-1:0] less1;
  assign less1       = count_i - 1'b1;
  assign occupancy_o = (count_i == '0) ? '0 : less1[OCC_W-1:0];
  assign half_o      = (count_i <= CNT_W'(DEPTH / 2));
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [ENTRY_W-1:0] head_i,
  input  logic               empty_i,
  output logic               pop_o,
  output logic               cmd_valid_o,
  output logic [2:0]         cmd_o,
  output logic [7:0]         cmd_byte_o,
  output logic               cmd_nack_o,
  input  logic               done_i,
  input  logic               nack_i,
  input  logic [7:0]         rd_data_i,
  output logic               rx_valid_o,
  output logic [7:0]         rx_data_o,
  output logic               tx_err_o,
  output logic               bus_free_o,
  output logic               owned_o
);
  seq_state_e         state;
  logic [ENTRY_W-1:0] cur;
  logic               exp_cnt;
  logic [7:0]         rd_left;
  logic               rd_stop;
  i2c_cmd_e           cmd;

  always_comb begin
    pop_o = 1'b0;
    case (state)
      S_IDLE:  pop_o = enable_i && !empty_i;
      S_FLUSH: pop_o = !empty_i && !head_i[START_B];
      default: ;
    endcase
  end

  always_comb begin
    case (state)
      S_COND:  cmd = owned_o ? CMD_RESTART : CMD_START;
      S_WRITE: cmd = CMD_WRITE;
      S_READ:  cmd = CMD_READ;
      S_STOP:  cmd = CMD_STOP;
      default: cmd = CMD_NONE;
    endcase
  end

  assign cmd_o       = cmd;
  assign cmd_valid_o = (cmd != CMD_NONE);
  assign cmd_byte_o  = (state == S_WRITE) ? cur[7:0] : 8'h00;
  assign cmd_nack_o  = (state == S_READ) && (rd_left == 8'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= S_IDLE;
      cur        <= '0;
      exp_cnt    <= 1'b0;
      rd_left    <= '0;
      rd_stop    <= 1'b0;
      owned_o    <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      tx_err_o   <= 1'b0;
      bus_free_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_err_o   <= 1'b0;
      bus_free_o <= 1'b0;
      case (state)
        S_IDLE: if (enable_i && !empty_i) begin
          cur <= head_i;
          if (exp_cnt) begin
            // entry after a read address is a byte count
            exp_cnt <= 1'b0;
            rd_left <= head_i[7:0];
            rd_stop <= head_i[STOP_B];
            if (head_i[7:0] != 8'd0) state <= S_READ;
            else if (head_i[STOP_B]) state <= S_STOP;
          end else if (head_i[START_B]) begin
            state <= S_COND;
          end else begin
            state <= S_WRITE;
          end
        end
        S_COND: if (done_i) begin
          owned_o <= 1'b1;
          state   <= S_WRITE;
        end
        S_WRITE: if (done_i) begin
          if (nack_i) begin
            tx_err_o <= 1'b1;
            state    <= S_FLUSH;
          end else if (cur[START_B] && cur[0]) begin
            exp_cnt <= 1'b1;
            state   <= S_IDLE;
          end else begin
            state <= cur[STOP_B] ? S_STOP : S_IDLE;
          end
        end
        S_READ: if (done_i) begin
          rx_valid_o <= 1'b1;
          rx_data_o  <= rd_data_i;
          rd_left    <= rd_left - 1'b1;
          if (rd_left == 8'd1) state <= rd_stop ? S_STOP : S_IDLE;
        end
        S_FLUSH: if (empty_i || head_i[START_B]) state <= S_STOP;
        S_STOP: if (done_i) begin
          owned_o    <= 1'b0;
          bus_free_o <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_cmd_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !done_i) |=> (cmd_valid_o && $stable(cmd_o) && $stable(cmd_byte_o) && $stable(cmd_nack_o)));
  assert_done_in_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> cmd_valid_o);
  assert_err_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> (state == S_FLUSH || state == S_STOP));
  assert_free_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_free_o |-> !owned_o);
  assert_last_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_READ && cmd_nack_o && done_i) |=> (cmd_o != CMD_READ));
  assert_hold_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE && !enable_i) |=> (state == S_IDLE));
endmodule

// File: rtl/i2c_dyn_seq.sv
module i2c_dyn_seq
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int OCC_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               fifo_rst_i,
  input  logic               push_i,
  input  logic [ENTRY_W-1:0] push_data_i,
  output logic [OCC_W-1:0]   occupancy_o,
  output logic               full_o,
  output logic               tx_empty_o,
  output logic               tx_half_o,
  output logic               cmd_valid_o,
  output logic [2:0]         cmd_o,
  output logic [7:0]         cmd_byte_o,
  output logic               cmd_nack_o,
  input  logic               done_i,
  input  logic               nack_i,
  input  logic [7:0]         rd_data_i,
  output logic               rx_valid_o,
  output logic [7:0]         rx_data_o,
  output logic               tx_err_o,
  output logic               bus_free_o,
  output logic               bus_owned_o
);
  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0]   count;
  logic               pop;

  i2c_seq_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk_i, .rst_ni,
    .clr_i   (fifo_rst_i),
    .push_i,
    .wdata_i (push_data_i),
    .pop_i   (pop && !fifo_rst_i),
    .head_o  (head),
    .count_o (count),
    .full_o,
    .empty_o (tx_empty_o)
  );

  i2c_seq_level #(.DEPTH(DEPTH)) u_level (
    .count_i     (count),
    .occupancy_o,
    .half_o      (tx_half_o)
  );

  i2c_seq_fsm u_fsm (
    .clk_i, .rst_ni, .enable_i,
    .head_i  (head),
    .empty_i (tx_empty_o),
    .pop_o   (pop),
    .cmd_valid_o, .cmd_o, .cmd_byte_o, .cmd_nack_o,
    .done_i, .nack_i, .rd_data_i,
    .rx_valid_o, .rx_data_o, .tx_err_o, .bus_free_o,
    .owned_o (bus_owned_o)
  );
endmodule

// File: tb/i2c_dyn_seq_tb.sv
module i2c_dyn_seq_tb;
  logic clk_i = 0, rst_ni = 0;
  logic enable_i = 0, fifo_rst_i = 0, push_i = 0;
  logic [9:0] push_data_i = '0;
  logic [3:0] occupancy_o;
  logic full_o, tx_empty_o, tx_half_o, cmd_valid_o, cmd_nack_o;
  logic [2:0] cmd_o;
  logic [7:0] cmd_byte_o, rd_data_i = '0, rx_data_o;
  logic done_i = 0, nack_i = 0;
  logic rx_valid_o, tx_err_o, bus_free_o, bus_owned_o;

  int total = 0, bad = 0, cycles = 0;
  int bf_cnt = 0, err_cnt = 0;
  logic [11:0] exp_q[$];
  logic [7:0]  rx_q[$];
  logic [7:0]  rd_seq = 8'hC0, exp_rd = 8'hC0;
  logic        nack_en = 0;
  logic [7:0]  nack_byte = '0;

  always #10 clk_i = ~clk_i;

  i2c_dyn_seq u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic exp_cmd(input int c, input logic [7:0] b, input bit n);
    exp_q.push_back({c[2:0], n, b});
  endtask

  task automatic exp_rx(input int n);
    for (int i = 0; i < n; i++) begin
      rx_q.push_back(exp_rd);
      exp_rd++;
    end
  endtask

  task automatic push(input logic [9:0] d);
    push_i = 1; push_data_i = d;
    @(negedge clk_i);
    push_i = 0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || cmd_valid_o) && n < 3000) begin
      @(negedge clk_i); n++;
    end
    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    chk(rx_q.size() == 0, "R7", rx_q.size(), 0);
    chk(tx_empty_o && tx_half_o, "R9", {tx_empty_o, tx_half_o}, 3);
  endtask

  // engine model and command monitor
  initial begin
    int wcnt = 0;
    logic [11:0] first = '0, got, want;
    forever begin
      @(negedge clk_i);
      if (done_i) begin
        done_i = 0; nack_i = 0; wcnt = 0;
      end else if (cmd_valid_o) begin
        got = {cmd_o, cmd_nack_o, cmd_byte_o};
        if (wcnt == 0) first = got;
        wcnt++;
        if (wcnt == 3) begin
          chk(got == first, "R10", got, first);
          done_i = 1;
          nack_i = nack_en && cmd_o == 3'd3 && cmd_byte_o == nack_byte;
          rd_data_i = rd_seq;
          if (cmd_o == 3'd4) rd_seq++;
          want = (exp_q.size() != 0) ? exp_q.pop_front() : 12'hFFF;
          chk(got == want, "R4/R5/R6/R8 cmd", got, want);
        end
      end
    end
  end

  // rx and event monitor
  initial forever begin
    @(negedge clk_i);
    if (bus_free_o) bf_cnt++;
    if (tx_err_o) err_cnt++;
    if (rx_valid_o) begin
      logic [7:0] w;
      w = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hxx;
      chk(rx_data_o === w, "R7", rx_data_o, w);
    end
  end

  initial begin
    forever begin
      @(posedge clk_i); cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(occupancy_o == 0 && tx_empty_o, "R1 reset", occupancy_o, 0);
    chk(!full_o && tx_half_o, "R9 reset", {full_o, tx_half_o}, 1);
    chk(!cmd_valid_o && !bus_owned_o, "R3 reset", cmd_valid_o, 0);

    // disabled: nothing consumed
    push(10'h1A0); push(10'h011); push(10'h212);
    repeat (10) @(negedge clk_i);
    chk(occupancy_o == 2, "R3", occupancy_o, 2);
    chk(!cmd_valid_o, "R3", cmd_valid_o, 0);
    fifo_rst_i = 1; @(negedge clk_i); fifo_rst_i = 0;
    chk(occupancy_o == 0 && tx_empty_o, "R2", occupancy_o, 0);

    // fill levels, full drop
    for (int i = 0; i < 8; i++) push(10'(i));
    chk(tx_half_o && occupancy_o == 7, "R9 half", occupancy_o, 7);
    push(10'h008);
    chk(!tx_half_o, "R9 half", tx_half_o, 0);
    for (int i = 9; i < 16; i++) push(10'(i));
    chk(full_o && occupancy_o == 15, "R1 full", occupancy_o, 15);
    push(10'h0EE);
    chk(full_o && occupancy_o == 15, "R1 drop", occupancy_o, 15);
    fifo_rst_i = 1; @(negedge clk_i); fifo_rst_i = 0;
    chk(tx_empty_o && !full_o, "R2", full_o, 0);

    enable_i = 1;
    // plain write with stop
    exp_cmd(1, 0, 0); exp_cmd(3, 8'hA0, 0); exp_cmd(3, 8'h11, 0);
    exp_cmd(3, 8'h12, 0); exp_cmd(5, 0, 0);
    push(10'h1A0); push(10'h011); push(10'h212);
    drain("R5 write");
    chk(bf_cnt == 1 && !bus_owned_o, "R5 free", bf_cnt, 1);

    // address-only write: start and stop on one entry
    exp_cmd(1, 0, 0); exp_cmd(3, 8'h42, 0); exp_cmd(5, 0, 0);
    push(10'h342);
    drain("R5 addr only");
    chk(bf_cnt == 2, "R5", bf_cnt, 2);

    // write then repeated-start read of 3 with stop
    exp_cmd(1, 0, 0); exp_cmd(3, 8'hA4, 0); exp_cmd(3, 8'h33, 0);
    exp_cmd(2, 0, 0); exp_cmd(3, 8'hA5, 0);
    exp_cmd(4, 0, 0); exp_cmd(4, 0, 0); exp_cmd(4, 0, 1); exp_cmd(5, 0, 0);
    exp_rx(3);
    push(10'h1A4); push(10'h033); push(10'h1A5); push(10'h203);
    drain("R4 R6 restart read");
    chk(bf_cnt == 3, "R6 stop", bf_cnt, 3);

    // read 1 without stop, then restart write
    exp_cmd(1, 0, 0); exp_cmd(3, 8'hA7, 0); exp_cmd(4, 0, 1);
    exp_cmd(2, 0, 0); exp_cmd(3, 8'h44, 0); exp_cmd(5, 0, 0);
    exp_rx(1);
    push(10'h1A7); push(10'h001); push(10'h344);
    drain("R6 no stop");
    chk(bf_cnt == 4, "R6", bf_cnt, 4);

    // nack on address: rest of message flushed
    nack_en = 1; nack_byte = 8'h60;
    exp_cmd(1, 0, 0); exp_cmd(3, 8'h60, 0); exp_cmd(5, 0, 0);
    push(10'h160); push(10'h001); push(10'h202);
    drain("R8 addr nack");
    chk(err_cnt == 1, "R8 err", err_cnt, 1);
    chk(bf_cnt == 5, "R8 stop", bf_cnt, 5);

    // nack mid data, next message still runs
    nack_byte = 8'h77;
    exp_cmd(1, 0, 0); exp_cmd(3, 8'h62, 0); exp_cmd(3, 8'h77, 0); exp_cmd(5, 0, 0);
    exp_cmd(1, 0, 0); exp_cmd(3, 8'h64, 0); exp_cmd(3, 8'h79, 0); exp_cmd(5, 0, 0);
    push(10'h162); push(10'h077); push(10'h278); push(10'h164); push(10'h279);
    drain("R8 data nack");
    chk(err_cnt == 2, "R8 err", err_cnt, 2);
    chk(bf_cnt == 7, "R5 R8", bf_cnt, 7);
    nack_en = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule